// File: doc/BRIEF.md
# Tracking Counter-Feedback ADC Controller

This block is the digital half of a converter that follows its analog input by negative feedback. It owns an up-down counter whose value is presented as the code for an external DAC. A single external comparator bit reports whether the analog input lies above the DAC level. On each step the counter moves one code toward the input: up when the input is higher, down otherwise. The counter stops at both ends of its range.

There is no start pulse and no conversion frame. The loop runs continuously. Once it reaches the input it dithers across the two codes that bracket the input level. The block reports this state by raising a valid flag and holding the lower of the two bracketing codes as the result. When the input moves, the loop walks one code per step toward the new level. So the time to a fresh result grows with the distance the input travelled. The counter waits a fixed number of clock cycles between steps, so the analog parts have time to respond.

Top module: `trk_adc_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block sets `dac_code` to mid-scale (only the top bit set), `result` to zero and `result_valid` to 0, and restarts the step timer.
- R2: After reset is released, the first step happens on the DAC_SETTLE-th rising edge. Further steps follow every DAC_SETTLE edges. `dac_code` changes only on a step, and by at most one code.
- R3: On a step, `cmp_above` = 1 raises `dac_code` by one and `cmp_above` = 0 lowers it by one. A comparator reading 0 for an input equal to the DAC level therefore moves the code down.
- R4: `dac_code` saturates: a step up at all-ones and a step down at all-zeros leave it unchanged. It never wraps.
- R5: A step whose direction differs from the direction of the previous step sets `result_valid` to 1. The same step loads `result` with the lower of the code before that step and the code after it.
- R6: A step in the same direction as the previous step clears `result_valid` and leaves `result` unchanged. This includes a step that is held at a range limit.
- R7: The first step after reset has no previous direction and never raises `result_valid`.
- R8: `result` and `result_valid` change only on step edges or under reset.
- R9: The number of cycles to the first valid result grows with the distance between the input and the current code. From mid-scale to an input between codes k and k+1, with k at or above mid-scale, it is (k - mid + 2) × DAC_SETTLE edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_above | input | 1 | Comparator: 1 when the analog input exceeds the DAC level |
| dac_code | output | N | Code driven to the external DAC (counter value) |
| result | output | N | Held conversion result, the lower code of the last bracket |
| result_valid | output | 1 | Tracking has settled on the current input |

## Verification
The bench builds the block with N = 6 and DAC_SETTLE = 3. A full-scale walk of 63 codes then takes under 200 cycles, so both saturation limits are reached within a short run. It also moves the input while the loop is settled, checks the case where the input equals the DAC level exactly, and compares settle times for a near target and a far target. A behavioural model of the DAC and comparator closes the loop from an input level held in half-code units. Odd levels fall between two codes and even levels sit exactly on a code.

// File: rtl/trk_adc_pkg.sv
// Package: shared types for the tracking converter controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package trk_adc_pkg;

    // Step direction chosen by the comparator.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } trk_dir_e;

endpackage

// File: rtl/trk_pace_timer.sv
// Module: trk_pace_timer
// Emits a one-cycle step strobe every SETTLE cycles. After a synchronous
// reset it emits the first strobe on the SETTLE-th cycle.
// Assumes SETTLE >= 1. With SETTLE = 1 the strobe is high on every cycle.
module trk_pace_timer #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int TW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [TW-1:0] LAST = TW'(SETTLE - 1);

    logic [TW-1:0] phase;

    // Strobe when the phase counter reaches its last value.
    assign tick = (phase == LAST);

    // Phase counter: restart on reset and after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (tick)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

endmodule

// File: rtl/trk_updown_cnt.sv
// Module: trk_updown_cnt
// Saturating up-down counter that supplies the DAC code. It also presents
// the value it would take on the next step, so the settle detector can
// compare the codes before and after the step.
// Assumes step is a one-cycle strobe and dir is valid while step is high.
module trk_updown_cnt
    import trk_adc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  trk_dir_e     dir,
    output logic [N-1:0] count,
    output logic [N-1:0] count_nxt
);

    localparam logic [N-1:0] MID  = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] FULL = {N{1'b1}};
    localparam logic [N-1:0] ZERO = {N{1'b0}};

    // Next code: one step in dir, held at either end of the range.
    always_comb begin
        if (dir == DIR_UP)
            count_nxt = (count == FULL) ? count : count + 1'b1;
        else
            count_nxt = (count == ZERO) ? count : count - 1'b1;
    end

    // Counter register: mid-scale on reset, advance on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= MID;
        else if (step)
            count <= count_nxt;
    end

endmodule

// File: rtl/trk_settle_det.sv
// Module: trk_settle_det
// Watches the direction of successive steps. A reversal means the loop is
// bracketing the input, so the detector latches the lower bracket code and
// raises valid. A repeated direction means the loop is walking, so it drops
// valid and holds the last result.
// Assumes cur_code and nxt_code are the codes before and after this step.
module trk_settle_det
    import trk_adc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  trk_dir_e     dir,
    input  logic [N-1:0] cur_code,
    input  logic [N-1:0] nxt_code,
    output logic [N-1:0] result,
    output logic         valid
);

    trk_dir_e     last_dir;
    logic         have_last;
    logic         reversal;
    logic [N-1:0] low_code;

    // Reversal: a previous step exists and it went the other way.
    assign reversal = have_last && (dir != last_dir);

    // Lower of the two codes that bracket the input.
    assign low_code = (nxt_code < cur_code) ? nxt_code : cur_code;

    // Direction history: remember the direction of the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_dir  <= DIR_DOWN;
            have_last <= 1'b0;
        end else if (step) begin
            last_dir  <= dir;
            have_last <= 1'b1;
        end
    end

    // Result and valid: update only when a step happens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
        end else if (step && have_last) begin
            valid <= reversal;
            if (reversal)
                result <= low_code;
        end
    end

endmodule

// File: rtl/trk_adc_ctrl.sv
// Module: trk_adc_ctrl (top)
// Continuous tracking converter controller. A pace timer spaces the steps,
// a saturating counter drives the DAC code, and a settle detector reports
// the bracketed result.
// Assumes cmp_above is synchronous to clk and has settled within DAC_SETTLE
// cycles of a DAC code change.
module trk_adc_ctrl
    import trk_adc_pkg::*;
#(
    parameter int N          = 8,
    parameter int DAC_SETTLE = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_above,
    output logic [N-1:0] dac_code,
    output logic [N-1:0] result,
    output logic         result_valid
);

    logic         step;
    trk_dir_e     dir;
    logic [N-1:0] code_nxt;

    // Map the comparator bit to a step direction.
    assign dir = cmp_above ? DIR_UP : DIR_DOWN;

    trk_pace_timer #(.SETTLE(DAC_SETTLE)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (step)
    );

    trk_updown_cnt #(.N(N)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .dir       (dir),
        .count     (dac_code),
        .count_nxt (code_nxt)
    );

    trk_settle_det #(.N(N)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .dir      (dir),
        .cur_code (dac_code),
        .nxt_code (code_nxt),
        .result   (result),
        .valid    (result_valid)
    );

endmodule

// File: rtl/trk_adc_ctrl_chk.sv
// Module: trk_adc_ctrl_chk
// Checker bound to trk_adc_ctrl. It sees only the ports and keeps its own
// cycle counter to know where the step edges fall.
module trk_adc_ctrl_chk #(
    parameter int N          = 8,
    parameter int DAC_SETTLE = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmp_above,
    input logic [N-1:0] dac_code,
    input logic [N-1:0] result,
    input logic         result_valid
);

    localparam logic [N-1:0] MID  = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] FULL = {N{1'b1}};

    logic        past_ok;
    int unsigned ctr;
    logic        tick_c;

    assign tick_c = (ctr == DAC_SETTLE - 1);

    // History guard: set once the previous edge saw reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Independent step-position counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctr <= 0;
        else if (tick_c) ctr <= 0;
        else             ctr <= ctr + 1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        (past_ok || rst_n) && $past(!rst_n) |-> (dac_code == MID) && !result_valid && (result == '0));

    p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (dac_code == $past(dac_code)) || (dac_code == $past(dac_code) + 1'b1)
                    || (dac_code == $past(dac_code) - 1'b1));

    p_step_only_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(tick_c) |-> $stable(dac_code));

    p_direction_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && (dac_code != $past(dac_code)) |-> ((dac_code > $past(dac_code)) == $past(cmp_above)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(dac_code) == FULL) |-> (dac_code != '0));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(dac_code) == '0) |-> (dac_code != FULL));

    p_hold_between_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(tick_c) |-> $stable(result) && $stable(result_valid));

endmodule

bind trk_adc_ctrl trk_adc_ctrl_chk #(.N(N), .DAC_SETTLE(DAC_SETTLE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_above    (cmp_above),
    .dac_code     (dac_code),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/sim_trk_adc_ctrl.sv
// Bench for trk_adc_ctrl: closes the loop through a behavioural DAC and
// comparator model and compares every cycle with a behavioural reference.
module sim_trk_adc_ctrl;

    localparam int N   = 6;
    localparam int S   = 3;
    localparam int MID = 1 << (N - 1);
    localparam int MAXC = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmp_above;
    logic [N-1:0] dac_code;
    logic [N-1:0] result;
    logic         result_valid;

    int vin_h = 2 * MID + 1;   // analog input in half-code units
    int n_chk = 0;
    int n_fail = 0;
    bit started = 0;
    bit done = 0;

    // Reference state.
    int m_cnt, m_tmr, m_prev, m_res, m_vld;

    always #5 clk = ~clk;

    // DAC plus comparator model.
    assign cmp_above = (vin_h > 2 * int'(dac_code));

    trk_adc_ctrl #(.N(N), .DAC_SETTLE(S)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_above    (cmp_above),
        .dac_code     (dac_code),
        .result       (result),
        .result_valid (result_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        int nxt;
        int up;
        started = 1;
        if (!rst_n) begin
            m_cnt = MID; m_tmr = 0; m_prev = -1; m_res = 0; m_vld = 0;
        end else if (m_tmr == S - 1) begin
            m_tmr = 0;
            up  = (vin_h > 2 * m_cnt) ? 1 : 0;
            nxt = up ? ((m_cnt == MAXC) ? m_cnt : m_cnt + 1)
                     : ((m_cnt == 0) ? 0 : m_cnt - 1);
            if (m_prev != -1) begin
                if (m_prev != up) begin
                    m_vld = 1;
                    m_res = (nxt < m_cnt) ? nxt : m_cnt;
                end else begin
                    m_vld = 0;
                end
            end
            m_prev = up;
            m_cnt  = nxt;
        end else begin
            m_tmr++;
        end
    end

    // Cycle compare away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check(int'(dac_code) == m_cnt, "R2/R3 dac_code", int'(dac_code), m_cnt);
            check(int'(result_valid) == m_vld, "R5/R6/R7 result_valid", int'(result_valid), m_vld);
            check(int'(result) == m_res, "R8 result", int'(result), m_res);
        end
    end

    // Wait for valid, counting rising edges since the call.
    task automatic wait_valid(output int edges);
        edges = 0;
        do begin
            @(negedge clk);
            edges++;
        end while (!result_valid && edges < 1000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(int'(dac_code) == MID, "R1 reset code", int'(dac_code), MID);
        check(result_valid == 1'b0, "R1 reset valid", int'(result_valid), 0);
        check(int'(result) == 0, "R1 reset result", int'(result), 0);
        rst_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    // Directed scenarios.
    initial begin
        int t_far;
        int t_near;
        vin_h = 2 * 40 + 1;
        do_reset();
        // R9: far target 40..41 from mid 32: (40-32+2) steps.
        wait_valid(t_far);
        check(t_far == 10 * S, "R9 far settle edges", t_far, 10 * S);
        check(int'(result) == 40, "R5 lower bracket code", int'(result), 40);
        // R7: the first step cannot have set valid, checked through the model.
        // Move the input while settled: R6 walk, then R5 new bracket.
        vin_h = 2 * 42 + 1;
        repeat (4 * S) @(negedge clk);
        wait_valid(t_near);
        check(int'(result) == 42, "R5 new bracket after move", int'(result), 42);
        // R4 top saturation.
        vin_h = 200;
        repeat (30 * S) @(negedge clk);
        check(int'(dac_code) == MAXC, "R4 saturate at full scale", int'(dac_code), MAXC);
        check(result_valid == 1'b0, "R6 valid low while pinned high", int'(result_valid), 0);
        check(int'(result) == 42, "R6 result held while walking", int'(result), 42);
        // R4 bottom saturation.
        vin_h = -1;
        repeat (70 * S) @(negedge clk);
        check(int'(dac_code) == 0, "R4 saturate at zero", int'(dac_code), 0);
        check(result_valid == 1'b0, "R6 valid low while pinned low", int'(result_valid), 0);
        // R9 near target, after a fresh reset.
        vin_h = 2 * 33 + 1;
        do_reset();
        wait_valid(t_near);
        check(t_near == 3 * S, "R9 near settle edges", t_near, 3 * S);
        check(t_near < t_far, "R9 near faster than far", t_near, t_far);
        check(int'(result) == 33, "R5 near bracket", int'(result), 33);
        // R3 input equal to a code: equal reads as not above, bracket 19/20.
        vin_h = 2 * 20;
        repeat (18 * S) @(negedge clk);
        wait_valid(t_near);
        check(int'(result) == 19, "R3 equal level brackets below", int'(result), 19);
        repeat (4 * S) @(negedge clk);
        finish_run();
    end

endmodule